// File: doc/BRIEF.md
# Clock Generator Power-Down Sequencer

This block decides when the outputs of a multi-output clock generator stop, when the oscillator and PLL may be switched off, and when the outputs come back. A single active-low pin carries two meanings. Straight after reset it qualifies supply power: nothing runs until the pin has been seen high. From then on, a low level on the same pin is a request to power down. The pin is asynchronous, so it passes through a two-flop synchronizer before any decision is made.

A power-down is accepted only after the synchronized request is low at two consecutive rising edges of the complement CPU clock. Each single-ended output then stops low at its own next falling edge. Each differential pair stops at the next falling edge of its complement leg. A per-pair mode bit selects how the pair is parked: driven (true high, complement low) or tri-stated (both low, driver off). The oscillator and PLL enables drop only once every output has parked.

When the pin returns high, the oscillator and PLL come back on and the outputs stay parked until the PLL reports lock. Tri-stated pairs are driven again after a configurable number of cycles, or earlier if lock arrives first. All the running clocks are level inputs sampled on the reference clock, so every edge is seen as a change between two samples.

Top module: `clkgen_pd_seq`

## Requirements
- R1: After reset the phase is powered down (2), every single-ended output is low, and the oscillator and PLL enables are low. This lasts until the synchronized pin is seen high, after which the phase becomes wait-for-lock (3) with both enables high.
- R2: The pin passes through two flops on the reference clock. A change on the pin reaches the control logic two cycles later.
- R3: In the running phase (0), a power-down is accepted only when the synchronized pin is low at two consecutive complement-CPU rising edges. The phase then becomes parking (1). A low pulse that covers only one such edge is ignored.
- R4: While parking, each single-ended output stops low on the cycle where its clock falls. No high pulse on that output is shortened.
- R5: While parking, each differential pair stops on the cycle where its true leg rises (its complement leg falls). With clocks no slower than twice the CPU period, the powered-down phase follows within 4 CPU periods of acceptance.
- R6: A parked pair with mode bit 0 shows true=1, complement=0, output enable=1. A parked pair with mode bit 1 shows true=0, complement=0, output enable=0. The two legs are never high together.
- R7: The oscillator and PLL enables go low one cycle after the last output has parked, and never while any output is running.
- R8: In the wait-for-lock phase the outputs stay parked until the PLL lock input is high. The phase then becomes running.
- R9: Tri-stated pairs are driven (true=1, complement=0, enable=1) TRI_CYC cycles after the wait-for-lock phase begins, or when running begins, whichever comes first.
- R10: In the running phase a parked single-ended output restarts only on a cycle where its clock is sampled low. A parked pair restarts only on a cycle where its true leg is sampled high. No runt pulse is produced.
- R11: The phase output encodes running=0, parking=1, powered down=2, wait-for-lock=3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pin_ni | input | 1 | Shared power-good / power-down request pin |
| pll_lock_i | input | 1 | PLL lock indication |
| cpuc_i | input | 1 | Complement CPU clock level |
| drive_mode_i | input | N_DIFF | Per-pair park style, 1 = tri-state |
| se_clk_i | input | N_SE | Free-running single-ended clock levels |
| diff_clk_i | input | N_DIFF | Free-running true-leg levels of the pairs |
| se_o | output | N_SE | Gated single-ended outputs |
| diff_t_o | output | N_DIFF | Pair true legs |
| diff_c_o | output | N_DIFF | Pair complement legs |
| diff_oe_o | output | N_DIFF | Pair output drive enables |
| osc_en_o | output | 1 | Oscillator power enable |
| pll_en_o | output | 1 | PLL power enable |
| phase_o | output | 2 | Current phase |

## Verification
The bench drives lanes whose periods differ from each other and from the CPU clock, so a lane that stops on the wrong edge or on another lane's edge shows up as a mismatch. One request pulse is too short to cover two CPU edges, which separates two-edge acceptance from single-edge acceptance. The wake-up cases vary the mode bits and the timing of lock: lock held low past the tri-state bound, lock already high, and lock arriving early. These tell apart the timed drive-back from the drive-back triggered by lock. High-pulse widths are measured on every single-ended output to catch truncated or runt pulses at stop and restart.

// File: rtl/clkgen_pd_pkg.sv
package clkgen_pd_pkg;
  typedef enum logic [1:0] {
    PH_RUN  = 2'd0,
    PH_PARK = 2'd1,
    PH_DOWN = 2'd2,
    PH_LOCK = 2'd3
  } pd_phase_e;
endpackage

// File: rtl/clkgen_pd_sync.sv
module clkgen_pd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end
  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/clkgen_pd_ctrl.sv
module clkgen_pd_ctrl
  import clkgen_pd_pkg::*;
#(
  parameter int TRI_CYC = 8
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      req_n_i,
  input  logic      cpuc_i,
  input  logic      pll_lock_i,
  input  logic      all_stop_i,
  output pd_phase_e phase_o,
  output logic      tri_rel_o
);
  localparam int TW = $clog2(TRI_CYC + 1);

  pd_phase_e      ph_q;
  logic           cpuc_q, hit_q, tri_rel_q;
  logic [TW-1:0]  tri_cnt_q;
  logic           cpuc_rise;

  assign cpuc_rise = cpuc_i & ~cpuc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q      <= PH_DOWN;
      cpuc_q    <= 1'b0;
      hit_q     <= 1'b0;
      tri_rel_q <= 1'b0;
      tri_cnt_q <= '0;
    end else begin
      cpuc_q <= cpuc_i;
      unique case (ph_q)
        PH_RUN: if (cpuc_rise) begin
          if (!req_n_i) begin
            if (hit_q) begin
              ph_q      <= PH_PARK;
              hit_q     <= 1'b0;
              tri_rel_q <= 1'b0;
            end else hit_q <= 1'b1;
          end else hit_q <= 1'b0;
        end
        PH_PARK: if (all_stop_i) ph_q <= PH_DOWN;
        PH_DOWN: begin
          tri_cnt_q <= '0;
          if (req_n_i) ph_q <= PH_LOCK;
        end
        PH_LOCK: begin
          tri_cnt_q <= tri_cnt_q + 1'b1;
          if (tri_cnt_q == TW'(TRI_CYC - 1)) tri_rel_q <= 1'b1;
          if (pll_lock_i) begin
            ph_q      <= PH_RUN;
            tri_rel_q <= 1'b1;
          end
        end
        default: ph_q <= PH_DOWN;
      endcase
    end
  end

  assign phase_o   = ph_q;
  assign tri_rel_o = tri_rel_q;
endmodule

// File: rtl/clkgen_pd_se_lane.sv
module clkgen_pd_se_lane (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  input  logic park_i,
  input  logic run_i,
  output logic stop_o,
  output logic out_o
);
  logic lvl_q, stop_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q  <= 1'b0;
      stop_q <= 1'b1;
    end else begin
      lvl_q <= lvl_i;
      // stop on falling edge, restart only in low phase
      if (park_i && !stop_q && lvl_q && !lvl_i) stop_q <= 1'b1;
      else if (run_i && stop_q && !lvl_i)       stop_q <= 1'b0;
    end
  end
  assign stop_o = stop_q;
  assign out_o  = stop_q ? 1'b0 : lvl_q;
endmodule

// File: rtl/clkgen_pd_diff_lane.sv
module clkgen_pd_diff_lane (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  input  logic mode_i,
  input  logic tri_rel_i,
  input  logic park_i,
  input  logic run_i,
  output logic stop_o,
  output logic t_o,
  output logic c_o,
  output logic oe_o
);
  logic lvl_q, stop_q, drv;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q  <= 1'b0;
      stop_q <= 1'b1;
    end else begin
      lvl_q <= lvl_i;
      // stop on complement falling edge, restart while true leg high
      if (park_i && !stop_q && !lvl_q && lvl_i) stop_q <= 1'b1;
      else if (run_i && stop_q && lvl_i)        stop_q <= 1'b0;
    end
  end
  assign drv    = ~mode_i | tri_rel_i;
  assign stop_o = stop_q;
  assign t_o    = stop_q ? drv  : lvl_q;
  assign c_o    = stop_q ? 1'b0 : ~lvl_q;
  assign oe_o   = stop_q ? drv  : 1'b1;
endmodule

// File: rtl/clkgen_pd_seq.sv
module clkgen_pd_seq
  import clkgen_pd_pkg::*;
#(
  parameter int N_SE    = 2,
  parameter int N_DIFF  = 2,
  parameter int TRI_CYC = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pin_ni,
  input  logic              pll_lock_i,
  input  logic              cpuc_i,
  input  logic [N_DIFF-1:0] drive_mode_i,
  input  logic [N_SE-1:0]   se_clk_i,
  input  logic [N_DIFF-1:0] diff_clk_i,
  output logic [N_SE-1:0]   se_o,
  output logic [N_DIFF-1:0] diff_t_o,
  output logic [N_DIFF-1:0] diff_c_o,
  output logic [N_DIFF-1:0] diff_oe_o,
  output logic              osc_en_o,
  output logic              pll_en_o,
  output logic [1:0]        phase_o
);
  logic              req_n_s, tri_rel, park, run, all_stop;
  logic [N_SE-1:0]   se_stop;
  logic [N_DIFF-1:0] df_stop;
  pd_phase_e         phase;

  clkgen_pd_sync #(.STAGES(2)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pin_ni), .q_o(req_n_s)
  );

  clkgen_pd_ctrl #(.TRI_CYC(TRI_CYC)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_n_i(req_n_s), .cpuc_i(cpuc_i),
    .pll_lock_i(pll_lock_i), .all_stop_i(all_stop), .phase_o(phase),
    .tri_rel_o(tri_rel)
  );

  assign park     = (phase == PH_PARK);
  assign run      = (phase == PH_RUN);
  assign all_stop = (&se_stop) & (&df_stop);

  for (genvar i = 0; i < N_SE; i++) begin : g_se
    clkgen_pd_se_lane u_lane (
      .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(se_clk_i[i]), .park_i(park),
      .run_i(run), .stop_o(se_stop[i]), .out_o(se_o[i])
    );
  end

  for (genvar j = 0; j < N_DIFF; j++) begin : g_df
    clkgen_pd_diff_lane u_lane (
      .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(diff_clk_i[j]),
      .mode_i(drive_mode_i[j]), .tri_rel_i(tri_rel), .park_i(park),
      .run_i(run), .stop_o(df_stop[j]), .t_o(diff_t_o[j]),
      .c_o(diff_c_o[j]), .oe_o(diff_oe_o[j])
    );
  end

  assign osc_en_o = (phase != PH_DOWN);
  assign pll_en_o = (phase != PH_DOWN);
  assign phase_o  = phase;
endmodule

// File: rtl/clkgen_pd_seq_chk.sv
module clkgen_pd_seq_chk #(
  parameter int N_SE   = 2,
  parameter int N_DIFF = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              pll_lock_i,
  input logic [N_DIFF-1:0] drive_mode_i,
  input logic [N_SE-1:0]   se_o,
  input logic [N_DIFF-1:0] diff_t_o,
  input logic [N_DIFF-1:0] diff_c_o,
  input logic [N_DIFF-1:0] diff_oe_o,
  input logic              osc_en_o,
  input logic              pll_en_o,
  input logic [1:0]        phase_o
);
  AST_OFF_OUTPUTS_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !osc_en_o |-> (se_o == '0)); // R7
  AST_OFF_PAIRS_PARKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pll_en_o |-> (diff_t_o == ~drive_mode_i && diff_c_o == '0 && diff_oe_o == ~drive_mode_i)); // R6
  AST_LEGS_NEVER_BOTH_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (diff_t_o & diff_c_o) == '0); // R6
  AST_UNDRIVEN_LEGS_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((diff_t_o | diff_c_o) & ~diff_oe_o) == '0); // R6
  AST_PARK_ONLY_FROM_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == 2'd1 && $past(phase_o) != 2'd1) |-> $past(phase_o) == 2'd0); // R3
  AST_HOLD_UNTIL_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == 2'd3 && !pll_lock_i) |=> phase_o == 2'd3); // R8
  AST_WAKE_FROM_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == 2'd3 && $past(phase_o) != 2'd3) |-> $past(phase_o) == 2'd2); // R1
endmodule

bind clkgen_pd_seq clkgen_pd_seq_chk #(.N_SE(N_SE), .N_DIFF(N_DIFF)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pll_lock_i(pll_lock_i),
  .drive_mode_i(drive_mode_i), .se_o(se_o), .diff_t_o(diff_t_o),
  .diff_c_o(diff_c_o), .diff_oe_o(diff_oe_o), .osc_en_o(osc_en_o),
  .pll_en_o(pll_en_o), .phase_o(phase_o)
);

// File: tb/clkgen_pd_seq_bench.sv
`timescale 1ns/1ps
module clkgen_pd_seq_bench;
  localparam int NS = 2, ND = 2, TC = 8;
  localparam int CPU_PER = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pin_n = 1'b0, lock = 1'b0, cpuc = 1'b0;
  logic [ND-1:0] mode = 2'b10;
  logic [NS-1:0] se_clk = '0;
  logic [ND-1:0] df_clk = '0;
  logic [NS-1:0] se_o;
  logic [ND-1:0] t_o, c_o, oe_o;
  logic osc_o, pll_o;
  logic [1:0] ph_o;

  int checks = 0, errors = 0, tick = 0, wdog = 0;

  always #10 clk = ~clk;

  clkgen_pd_seq #(.N_SE(NS), .N_DIFF(ND), .TRI_CYC(TC)) u_clkgen_pd_seq (
    .clk_i(clk), .rst_ni(rst_n), .pin_ni(pin_n), .pll_lock_i(lock),
    .cpuc_i(cpuc), .drive_mode_i(mode), .se_clk_i(se_clk),
    .diff_clk_i(df_clk), .se_o(se_o), .diff_t_o(t_o), .diff_c_o(c_o),
    .diff_oe_o(oe_o), .osc_en_o(osc_o), .pll_en_o(pll_o), .phase_o(ph_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int  m_ph = 2, m_hit = 0, m_tcnt = 0;
  bit  m_rel = 0, m_s1 = 0, m_s2 = 0, m_cp = 0;
  bit  m_sp[NS], m_ss[NS], m_dp[ND], m_ds[ND];

  task automatic model_reset();
    m_ph = 2; m_hit = 0; m_tcnt = 0; m_rel = 0; m_s1 = 0; m_s2 = 0; m_cp = 0;
    for (int i = 0; i < NS; i++) begin m_sp[i] = 0; m_ss[i] = 1; end
    for (int i = 0; i < ND; i++) begin m_dp[i] = 0; m_ds[i] = 1; end
  endtask

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else begin
      bit all, rise;
      all = 1;
      for (int i = 0; i < NS; i++) all &= m_ss[i];
      for (int i = 0; i < ND; i++) all &= m_ds[i];
      rise = cpuc && !m_cp;
      for (int i = 0; i < NS; i++) begin
        if (m_ph == 1 && !m_ss[i] && m_sp[i] && !se_clk[i]) m_ss[i] = 1;
        else if (m_ph == 0 && m_ss[i] && !se_clk[i]) m_ss[i] = 0;
        m_sp[i] = se_clk[i];
      end
      for (int i = 0; i < ND; i++) begin
        if (m_ph == 1 && !m_ds[i] && !m_dp[i] && df_clk[i]) m_ds[i] = 1;
        else if (m_ph == 0 && m_ds[i] && df_clk[i]) m_ds[i] = 0;
        m_dp[i] = df_clk[i];
      end
      case (m_ph)
        0: if (rise) begin
             if (!m_s2) begin
               if (m_hit == 1) begin m_ph = 1; m_hit = 0; m_rel = 0; end
               else m_hit = 1;
             end else m_hit = 0;
           end
        1: if (all) m_ph = 2;
        2: begin m_tcnt = 0; if (m_s2) m_ph = 3; end
        default: begin
          m_tcnt++;
          if (m_tcnt == TC) m_rel = 1;
          if (lock) begin m_ph = 0; m_rel = 1; end
        end
      endcase
      m_cp = cpuc;
      m_s2 = m_s1;
      m_s1 = pin_n;
    end
  end

  // compare, pulse-width monitor, stimulus clocks, watchdog
  int hi_cnt[NS];
  int hw[NS] = '{3, 5};
  always @(negedge clk) begin
    if (rst_n) begin
      logic [NS-1:0] e_se;
      logic [ND-1:0] e_t, e_c, e_oe;
      for (int i = 0; i < NS; i++) e_se[i] = m_ss[i] ? 1'b0 : m_sp[i];
      for (int i = 0; i < ND; i++) begin
        bit drv;
        drv = !mode[i] || m_rel;
        e_t[i]  = m_ds[i] ? drv : m_dp[i];
        e_c[i]  = m_ds[i] ? 1'b0 : !m_dp[i];
        e_oe[i] = m_ds[i] ? drv : 1'b1;
      end
      chk(se_o == e_se, "R4/R10 se_o", se_o, e_se);
      chk({t_o, c_o} == {e_t, e_c}, "R5/R6 pair legs", {t_o, c_o}, {e_t, e_c});
      chk(oe_o == e_oe, "R9 pair enable", oe_o, e_oe);
      chk(osc_o == (m_ph != 2) && pll_o == (m_ph != 2), "R7 power enables",
          {osc_o, pll_o}, {2{m_ph != 2}});
      chk(ph_o == 2'(m_ph), "R11 phase", ph_o, m_ph);
      for (int i = 0; i < NS; i++) begin
        if (se_o[i]) hi_cnt[i]++;
        else if (hi_cnt[i] > 0) begin
          chk(hi_cnt[i] == hw[i], "R10 se high width", hi_cnt[i], hw[i]);
          hi_cnt[i] = 0;
        end
      end
    end
    tick++;
    cpuc      = (tick % 4) >= 2;
    df_clk[0] = (tick % 4) < 2;
    df_clk[1] = (tick % 8) >= 4;
    se_clk[0] = (tick % 6) >= 3;
    se_clk[1] = (tick % 10) >= 5;
    wdog++;
    if (wdog > 20000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<20000", wdog);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic power_down_measure();
    int t_park, t_down;
    t_park = 0; t_down = 0;
    pin_n = 1'b0;
    while (ph_o != 2'd1) begin cyc(1); t_park++; end
    while (ph_o != 2'd2) begin cyc(1); t_down++; end
    chk(t_park <= 3 + 2 * CPU_PER, "R3 accept latency", t_park, 3 + 2 * CPU_PER);
    chk(t_down <= 4 * CPU_PER, "R5 park within 4 periods", t_down, 4 * CPU_PER);
  endtask

  initial begin
    for (int i = 0; i < NS; i++) hi_cnt[i] = 0;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    chk(ph_o == 2'd2 && !osc_o && !pll_o && se_o == '0, "R1 reset state",
        {ph_o, osc_o, pll_o, se_o}, {2'd2, 4'b0});
    chk(t_o == 2'b01 && oe_o == 2'b01 && c_o == 2'b00, "R6 reset park styles",
        {t_o, oe_o, c_o}, 6'b010100);
    cyc(20);
    chk(ph_o == 2'd2, "R1 stays down before power good", ph_o, 2);
    pin_n = 1'b1;
    cyc(2);
    chk(ph_o == 2'd2, "R2 sync delay", ph_o, 2);
    cyc(1);
    chk(ph_o == 2'd3 && osc_o, "R1 wake to lock wait", ph_o, 3);
    cyc(TC - 1);
    chk(oe_o == 2'b01, "R9 tri pair still undriven", oe_o, 2'b01);
    cyc(1);
    chk(oe_o == 2'b11 && t_o == 2'b11, "R9 tri pair driven after bound", {oe_o, t_o}, 4'hf);
    cyc(5);
    chk(ph_o == 2'd3, "R8 holds without lock", ph_o, 3);
    lock = 1'b1;
    cyc(60);
    chk(ph_o == 2'd0, "R8 running after lock", ph_o, 0);
    // short request: covers at most one cpuc rising edge
    pin_n = 1'b0;
    cyc(2);
    pin_n = 1'b1;
    cyc(30);
    chk(ph_o == 2'd0, "R3 single edge request ignored", ph_o, 0);
    power_down_measure();
    chk(se_o == '0 && t_o == 2'b01 && oe_o == 2'b01, "R6 down with mode 10",
        {se_o, t_o, oe_o}, 6'b000101);
    mode = 2'b01;
    cyc(1);
    chk(t_o == 2'b10 && oe_o == 2'b10, "R6 live mode change", {t_o, oe_o}, 4'b1010);
    pin_n = 1'b1;
    cyc(60);
    chk(ph_o == 2'd0 && oe_o == 2'b11, "R9 drive on lock already high", {ph_o, oe_o}, 2'b11);
    mode = 2'b11;
    lock = 1'b0;
    power_down_measure();
    chk(oe_o == 2'b00 && t_o == 2'b00, "R6 both tri-stated", {oe_o, t_o}, 0);
    pin_n = 1'b1;
    cyc(5);
    lock = 1'b1;
    cyc(1);
    chk(oe_o == 2'b11, "R9 early drive on lock", oe_o, 2'b11);
    cyc(60);
    chk(ph_o == 2'd0, "R10 running again", ph_o, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule